// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches one 32-bit word from an external serial EEPROM on behalf of software. Three registers sit behind a small word-wide register port. Software puts the word address into the address register and writes the go bit of the control register. It then polls the ready flag in the same register until the flag is set again, and reads the assembled word from the data register.

Each fetch is a single SPI mode-0 transaction. Chip select is held low throughout. The block sends the read opcode and a 24-bit address, then clocks in four bytes. The serial clock runs at a fixed division of the system clock, set by a parameter. Only the lower 18 address bits can be used. A go request whose address has any higher bit set is dropped without any bus activity.

Top module: `eep_read_ctrl`

## Requirements
- R1: After reset the ready flag reads 1, the data register reads 0, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: The control register is at offset 0x10, with ready at bit 7. The address register is at offset 0x14 and reads back the full 32-bit value last written. The data register is at offset 0x18. Any other offset reads 0.
- R3: A write to 0x10 with bit 4 set, while ready is 1 and address bits 31:18 are all 0, clears ready and drives `spi_cs_n` low at the next clock edge.
- R4: A go request is ignored when address bits 31:18 are not all 0. Ready stays 1 and `spi_cs_n` stays high.
- R5: A go request made while ready is 0 is ignored. This includes a request in the last cycle of a fetch.
- R6: The first 32 bits sent on `spi_mosi` are, MSB first, the opcode 0x03 followed by the address zero-extended to 24 bits. The transaction has exactly 64 rising edges of `spi_sclk`.
- R7: The first byte received lands in data bits 7:0 and the fourth byte lands in bits 31:24. Within each byte the first bit received is the most significant.
- R8: Each `spi_sclk` phase lasts HALF_DIV system cycles. `spi_cs_n` is low for exactly 128*HALF_DIV cycles per fetch. `spi_sclk` rises only while `spi_cs_n` is low.
- R9: Ready returns to 1 exactly 128*HALF_DIV cycles after the accepted go request, with the new word already in the data register.
- R10: The data register changes only when a fetch completes. Writes to offset 0x18 are ignored, and so are writes to control bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| spi_sclk | output | 1 | Serial clock to the EEPROM |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |

## Verification
Fetch completion and a new go request can occur in the same clock cycle. Ready is still 0 during that cycle, so the request must be dropped. The bench counts 128*HALF_DIV-1 edges after an accepted start. It then writes the go bit in exactly the final cycle of the fetch. In that cycle it checks that ready still reads 0. On the following cycle it checks that ready reads 1, that the data word is correct, and that chip select stays high afterwards.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam logic [7:0] OFF_CTRL = 8'h10;
    localparam logic [7:0] OFF_ADDR = 8'h14;
    localparam logic [7:0] OFF_DATA = 8'h18;
    localparam int         BIT_GO    = 4;
    localparam int         BIT_READY = 7;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam int         WORD_W    = 32;
    localparam int         SPI_AW    = 24;
    localparam int         FRAME_BITS = 8 + SPI_AW + WORD_W;

    typedef enum logic [0:0] {ENG_IDLE = 1'b0, ENG_SHIFT = 1'b1} eng_state_e;
endpackage

// File: rtl/eep_sclk_div.sv
module eep_sclk_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/eep_spi_engine.sv
module eep_spi_engine
    import eep_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SPI_AW-1:0] addr,
    output logic              done,
    output logic [WORD_W-1:0] word,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int BCW = $clog2(FRAME_BITS);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_BITS - 1);
    localparam int CMD_BITS = 8 + SPI_AW;

    typedef struct packed {
        eng_state_e          st;
        logic                sclk;
        logic                cs_n;
        logic [BCW-1:0]      bit_cnt;
        logic [CMD_BITS-1:0] tx;
        logic [WORD_W-1:0]   rx;
    } eng_t;

    eng_t st_d, st_q;
    logic tick;

    eep_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st_q.st == ENG_SHIFT),
        .tick (tick)
    );

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        case (st_q.st)
            ENG_IDLE: begin
                if (start) begin
                    st_d.st      = ENG_SHIFT;
                    st_d.cs_n    = 1'b0;
                    st_d.sclk    = 1'b0;
                    st_d.bit_cnt = '0;
                    st_d.tx      = {OPC_READ, addr};
                    st_d.rx      = '0;
                end
            end
            default: begin
                if (tick) begin
                    if (!st_q.sclk) begin
                        st_d.sclk = 1'b1;
                        if (st_q.bit_cnt >= BCW'(CMD_BITS))
                            st_d.rx = {st_q.rx[WORD_W-2:0], miso};
                    end else begin
                        st_d.sclk = 1'b0;
                        if (st_q.bit_cnt == LAST_BIT) begin
                            st_d.st   = ENG_IDLE;
                            st_d.cs_n = 1'b1;
                            done      = 1'b1;
                        end else begin
                            st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                            st_d.tx      = {st_q.tx[CMD_BITS-2:0], 1'b0};
                        end
                    end
                end
            end
        endcase
    end

    generate
        for (genvar b = 0; b < WORD_W / 8; b++) begin : g_swap
            assign word[8*b +: 8] = st_q.rx[WORD_W-8-8*b +: 8];
        end
    endgenerate

    assign sclk = st_q.sclk;
    assign cs_n = st_q.cs_n;
    assign mosi = st_q.cs_n ? 1'b0 : st_q.tx[CMD_BITS-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st      <= ENG_IDLE;
            st_q.sclk    <= 1'b0;
            st_q.cs_n    <= 1'b1;
            st_q.bit_cnt <= '0;
            st_q.tx      <= '0;
            st_q.rx      <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/eep_read_ctrl.sv
module eep_read_ctrl
    import eep_pkg::*;
#(
    parameter int HALF_DIV  = 2,
    parameter int ADDR_BITS = 18
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    typedef struct packed {
        logic              ready;
        logic [31:0]       addr;
        logic [WORD_W-1:0] data;
    } regs_t;

    regs_t regs_d, regs_q;
    logic eng_start, eng_done;
    logic [WORD_W-1:0] eng_word;
    logic [SPI_AW-1:0] eng_addr;
    logic addr_ok;
    logic ready_w;
    logic [WORD_W-1:0] data_w;

    assign addr_ok  = (regs_q.addr >> ADDR_BITS) == 32'd0;
    assign eng_addr = SPI_AW'(regs_q.addr[ADDR_BITS-1:0]);
    assign ready_w  = regs_q.ready;
    assign data_w   = regs_q.data;

    always_comb begin
        regs_d    = regs_q;
        eng_start = 1'b0;
        if (reg_wr && reg_addr == OFF_CTRL && reg_wdata[BIT_GO]
            && regs_q.ready && addr_ok) begin
            eng_start    = 1'b1;
            regs_d.ready = 1'b0;
        end
        if (reg_wr && reg_addr == OFF_ADDR)
            regs_d.addr = reg_wdata;
        if (eng_done) begin
            regs_d.ready = 1'b1;
            regs_d.data  = eng_word;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CTRL: reg_rdata[BIT_READY] = regs_q.ready;
            OFF_ADDR: reg_rdata = regs_q.addr;
            OFF_DATA: reg_rdata = regs_q.data;
            default:  reg_rdata = '0;
        endcase
    end

    eep_spi_engine #(.HALF_DIV(HALF_DIV)) u_eng (
        .clk  (clk),
        .rst_n(rst_n),
        .start(eng_start),
        .addr (eng_addr),
        .done (eng_done),
        .word (eng_word),
        .sclk (spi_sclk),
        .cs_n (spi_cs_n),
        .mosi (spi_mosi),
        .miso (spi_miso)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.ready <= 1'b1;
            regs_q.addr  <= '0;
            regs_q.data  <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/eep_read_ctrl_chk.sv
module eep_read_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] addr_reg,
    input logic        ready,
    input logic [31:0] data,
    input logic        sclk,
    input logic        cs_n
);
    // R3: an accepted start drops chip select in the same cycle ready clears
    p_start_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> !cs_n);

    // R4: a go request with high address bits leaves ready set
    p_bad_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h10 && reg_wdata[4] && ready
         && addr_reg[31:18] != 14'd0) |=> ready);

    // R5: a go request while busy keeps ready low
    p_busy_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !cs_n && reg_wr && reg_addr == 8'h10) |=> (!ready || cs_n));

    // R8: serial clock rises only inside a transaction
    p_sclk_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> !cs_n);

    // R1: idle bus while ready
    p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cs_n && !sclk));

    // R10: data holds while the interface stays idle
    p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready)) |-> $stable(data));
endmodule

bind eep_read_ctrl eep_read_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .addr_reg (regs_q.addr),
    .ready    (ready_w),
    .data     (data_w),
    .sclk     (spi_sclk),
    .cs_n     (spi_cs_n)
);

// File: tb/sim_eep_read_ctrl.sv
`timescale 1ns/1ps
module sim_eep_read_ctrl;
    localparam int HD = 2;
    localparam int FETCH = 128 * HD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic spi_sclk, spi_cs_n, spi_mosi;
    logic spi_miso = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    eep_read_ctrl #(.HALF_DIV(HD), .ADDR_BITS(18)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // EEPROM model
    int rises = 0;
    int low_cycles = 0;
    logic [31:0] cmd_cap = 32'h0;

    function automatic logic [7:0] mem_b(input logic [23:0] a);
        return a[7:0] ^ {a[17:16], a[13:8]} ^ 8'h5A;
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] a);
        logic [23:0] b;
        b = {6'h0, a[17:0]};
        return {mem_b(b + 24'd3), mem_b(b + 24'd2), mem_b(b + 24'd1), mem_b(b)};
    endfunction

    always @(negedge spi_cs_n) begin
        rises = 0;
        cmd_cap = 32'h0;
        low_cycles = 0;
    end
    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            if (rises < 32) cmd_cap = {cmd_cap[30:0], spi_mosi};
            rises = rises + 1;
        end
    end
    always @(negedge spi_sclk) begin
        if (!spi_cs_n && rises >= 32 && rises < 64) begin
            int idx;
            idx = rises - 32;
            spi_miso = mem_b(cmd_cap[23:0] + 24'(idx / 8))[7 - (idx % 8)];
        end
    end
    always @(negedge clk) if (!spi_cs_n) low_cycles = low_cycles + 1;

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_ready(output bit ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            rd(8'h10, v);
            if (v[7]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic fetch(input logic [31:0] a);
        logic [31:0] v;
        bit ok;
        wr(8'h14, a);
        wr(8'h10, 32'h10);
        #1;
        check(reg_rdata[7] == 1'b0 || reg_addr != 8'h10, "R3 ready cleared", {31'h0, reg_rdata[7]}, 32'h0);
        check(spi_cs_n == 1'b0, "R3 cs low", {31'h0, spi_cs_n}, 32'h0);
        wait_ready(ok);
        check(ok, "R9 ready returns", {31'h0, ok}, 32'h1);
        check(cmd_cap == {8'h03, 6'h0, a[17:0]}, "R6 command frame", cmd_cap, {8'h03, 6'h0, a[17:0]});
        check(rises == 64, "R6 clock count", 32'(rises), 32'd64);
        check(low_cycles == FETCH, "R8 cs low cycles", 32'(low_cycles), 32'(FETCH));
        rd(8'h18, v);
        check(v == exp_word(a), "R7 data word", v, exp_word(a));
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin : main
        logic [31:0] v, prev;
        bit ok;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 bus idle in reset", {30'h0, spi_cs_n, spi_sclk}, 32'h2);
        rst_n = 1'b1;
        rd(8'h10, v); check(v == 32'h80, "R1 ready after reset", v, 32'h80);
        rd(8'h18, v); check(v == 32'h0, "R1 data after reset", v, 32'h0);

        // R2 map
        wr(8'h14, 32'hA5C3_0F0F);
        rd(8'h14, v); check(v == 32'hA5C3_0F0F, "R2 address readback", v, 32'hA5C3_0F0F);
        rd(8'h1C, v); check(v == 32'h0, "R2 unmapped offset", v, 32'h0);

        // R4 illegal address
        wr(8'h10, 32'h10);
        rd(8'h10, v); check(v == 32'h80, "R4 ready unchanged", v, 32'h80);
        check(spi_cs_n == 1'b1, "R4 no transaction", {31'h0, spi_cs_n}, 32'h1);

        // directed corners
        fetch(32'h0000_0000);
        fetch(32'h0003_FFFF);
        fetch(32'h0001_2345);

        // R10 writes to data and ready ignored
        rd(8'h18, prev);
        wr(8'h18, 32'hDEAD_BEEF);
        wr(8'h10, 32'h0000_0080);
        rd(8'h18, v); check(v == prev, "R10 data write ignored", v, prev);
        rd(8'h10, v); check(v == 32'h80, "R10 ready write ignored", v, 32'h80);

        // random mix of legal and illegal addresses
        for (int n = 0; n < 10; n++) begin
            logic [31:0] a;
            a = $urandom();
            if (n % 3 != 0) a[31:18] = '0;
            if (a[31:18] != 0) begin
                rd(8'h18, prev);
                wr(8'h14, a);
                wr(8'h10, 32'h10);
                rd(8'h10, v); check(v == 32'h80, "R4 random bad address", v, 32'h80);
                rd(8'h18, v); check(v == prev, "R4 data unchanged", v, prev);
            end else begin
                fetch(a);
            end
        end

        // R5 start while busy, and R9 collision with completion
        wr(8'h14, 32'h0000_0100);
        wr(8'h10, 32'h10);
        wr(8'h14, 32'h0000_0200);
        wr(8'h10, 32'h10);
        check(spi_cs_n == 1'b0, "R5 still busy", {31'h0, spi_cs_n}, 32'h0);
        wait_ready(ok);
        rd(8'h18, v); check(v == exp_word(32'h100), "R5 busy start ignored", v, exp_word(32'h100));

        wr(8'h14, 32'h0000_0777);
        wr(8'h10, 32'h10);
        repeat (FETCH - 1) @(posedge clk);
        @(negedge clk);
        reg_addr = 8'h10; reg_wdata = 32'h10; reg_wr = 1'b1;
        #1 check(reg_rdata[7] == 1'b0, "R9 ready low in last cycle", reg_rdata, 32'h0);
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        #1 check(reg_rdata[7] == 1'b1, "R9 ready exactly on time", reg_rdata, 32'h80);
        check(spi_cs_n == 1'b1, "R5 colliding start ignored", {31'h0, spi_cs_n}, 32'h1);
        repeat (20) @(negedge clk);
        check(spi_cs_n == 1'b1, "R5 no late transaction", {31'h0, spi_cs_n}, 32'h1);
        rd(8'h18, v); check(v == exp_word(32'h777), "R9 data with ready", v, exp_word(32'h777));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule